// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The block is the transmit side of a descriptor-driven network controller. Software builds a ring of 16-byte descriptors in memory and gives the hardware ownership of the ones it wants sent. It then pulses a doorbell. The engine walks the ring through a word-wide memory request/response port. For each owned descriptor it reads the length and the buffer pointer and streams the buffer out as bytes on a valid/ready interface. When the frame has gone out, it writes the control word back with the ownership bit cleared.

The ring position is an index that counts descriptor slots from a 256-byte-aligned base. A descriptor can end the ring and send the walk back to slot 0. Every other descriptor moves it one slot ahead. The engine keeps polling after each frame and stops only when it meets a descriptor it does not own. A doorbell that arrives while the engine is busy is held, so the engine makes one more pass after it stops. Frames are sent at exactly the length given, with no padding. Each frame must fit in a single descriptor. A descriptor whose frame flags do not describe a whole frame is handed back unsent, with an error pulse.

Descriptor word 0 (offset 0) carries control and length. Word 2 (offset 8) holds the buffer byte address. Words 1 and 3 are not read.

Top module: `txring_engine`

## Requirements
- R1: Out of reset, txValid, memReqValid and descError are low, and no memory request is issued until a doorbell pulse arrives.
- R2: A doorbell while idle starts a read of descriptor word 0 at address {ringBaseHi, 8'h00} + 16 * index, where index counts ring slots.
- R3: A write of ringBaseHi (baseWe high) sets the ring index to 0.
- R4: A descriptor is sendable when word 0 bit 31 (owned) is 1 and both bit 29 (frame start) and bit 28 (frame end) are 1. The engine then reads word 2 at offset 8 as a byte address. It streams exactly bits 15:0 bytes from that address in rising address order, taking byte lane k of each little-endian memory word for address bits 1:0 = k. Any buffer alignment is allowed, and frames under 60 bytes are not padded.
- R5: A sendable descriptor with length 0 puts no bytes on the stream and is still handed back as in R6.
- R6: After a descriptor is finished, the engine writes its word 0 back to the same address, with bit 31 cleared and all other bits unchanged.
- R7: After the hand-back, the index becomes 0 if word 0 bit 30 (end of ring) was set, and index + 1 (modulo 2^IDX_W) otherwise. The engine then fetches the next descriptor without waiting for a doorbell.
- R8: A fetched word 0 with bit 31 clear produces no write and no bytes. The engine then issues no further requests until a doorbell.
- R9: A doorbell that arrives while the engine is not idle is remembered. After the engine next stops on an unowned descriptor, it fetches that descriptor once more.
- R10: An owned descriptor that lacks bit 29 or bit 28 sends no bytes and pulses descError high for exactly one cycle. It is handed back as in R6 and the index advances as in R7.
- R11: While txValid is high and txReady low, txValid stays high and txData holds. While memReqValid is high and memReqReady low, the request stays up with address, direction and write data unchanged.
- R12: At most one read is outstanding: no request is made between an accepted read and its response. Every request address is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWe | input | 1 | Ring base write strobe; also clears the ring index |
| ringBaseHi | input | AW-8 | Ring base address bits AW-1:8 (base is 256-byte aligned) |
| doorbell | input | 1 | One-cycle pulse that starts ring polling |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted this cycle |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Word-aligned byte address of the request |
| memWdata | output | 32 | Write data (descriptor hand-back) |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 32 | Read data |
| txValid | output | 1 | Frame byte valid |
| txReady | input | 1 | Downstream accepts the byte |
| txData | output | 8 | Frame byte |
| descError | output | 1 | One-cycle pulse: owned descriptor with bad frame flags |

## Verification
The checker assumes the memory returns exactly one response per accepted read, at least one cycle after acceptance, and never returns one unasked. It also assumes software leaves the base register and the descriptors the engine owns alone while the engine is walking the ring. The bench memory model answers each accepted read on the next cycle and randomly withholds memReqReady and txReady. The bench rewrites descriptors, moves the base and rings the doorbell only after a quiet period long enough for the engine to reach an unowned descriptor. The one exception is the held-doorbell case, where the doorbell is rung on purpose in mid-frame without touching memory.

// File: rtl/txring_pkg.sv
package txring_pkg;

  // Descriptor word 0 fields; the bit positions are shared with software.
  localparam int OWN_BIT   = 31;
  localparam int EOR_BIT   = 30;
  localparam int FIRST_BIT = 29;
  localparam int LAST_BIT  = 28;
  localparam int LEN_W     = 16;
  localparam int DW        = 32;
  localparam int SLOT_SH   = 4;   // 16-byte descriptors
  localparam int PTR_OFS   = 8;   // word 2 holds the buffer pointer
  localparam int ALIGN_W   = 8;   // ring base aligned to 256 bytes

  typedef enum logic [1:0] {
    SEL_HEAD = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_DATA = 2'd2
  } addrSel_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    addrSel_t addrSel;
    logic     loadHead;
    logic     loadPtr;
    logic     loadWord;
    logic     stepByte;
    logic     advance;
  } strobes_t;

  // Datapath-to-control conditions.
  typedef struct packed {
    logic owned;
    logic single;
    logic lenZero;
    logic lastByte;
    logic wordEnd;
  } dpStatus_t;

endpackage

// File: rtl/txring_dp.sv
module txring_dp
  import txring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baseWe,
  input  logic [AW-1:ALIGN_W]  ringBaseHi,
  input  strobes_t             stb,
  input  logic [DW-1:0]        memRespData,
  output logic [AW-1:0]        memAddr,
  output logic [DW-1:0]        memWdata,
  output logic [7:0]           txData,
  output dpStatus_t            status
);

  localparam int LANES = DW / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [AW-1:ALIGN_W] baseHi;
  logic [IDX_W-1:0]    idx;
  logic [DW-1:0]       head;
  logic [AW-1:0]       bufPtr;
  logic [LEN_W-1:0]    remain;
  logic [DW-1:0]       word;
  logic [AW-1:0]       slotAddr;
  logic [7:0]          lanes [LANES];

  assign slotAddr = {baseHi, {ALIGN_W{1'b0}}} + AW'({idx, {SLOT_SH{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi <= '0;
      idx    <= '0;
      head   <= '0;
      bufPtr <= '0;
      remain <= '0;
      word   <= '0;
    end else begin
      if (baseWe) begin
        baseHi <= ringBaseHi;
        idx    <= '0;
      end else if (stb.advance) begin
        idx <= head[EOR_BIT] ? '0 : idx + 1'b1;
      end
      if (stb.loadHead) head <= memRespData;
      if (stb.loadPtr) begin
        bufPtr <= AW'(memRespData);
        remain <= head[LEN_W-1:0];
      end else if (stb.stepByte) begin
        bufPtr <= bufPtr + 1'b1;
        remain <= remain - 1'b1;
      end
      if (stb.loadWord) word <= memRespData;
    end
  end

  always_comb begin
    unique case (stb.addrSel)
      SEL_PTR:  memAddr = slotAddr + AW'(PTR_OFS);
      SEL_DATA: memAddr = {bufPtr[AW-1:LANE_W], {LANE_W{1'b0}}};
      default:  memAddr = slotAddr;
    endcase
  end

  // Hand-back word: ownership returned, every other bit kept.
  assign memWdata = {1'b0, head[DW-2:0]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end
  assign txData = lanes[bufPtr[LANE_W-1:0]];

  assign status.owned    = head[OWN_BIT];
  assign status.single   = head[FIRST_BIT] & head[LAST_BIT];
  assign status.lenZero  = (head[LEN_W-1:0] == '0);
  assign status.lastByte = (remain == LEN_W'(1));
  assign status.wordEnd  = (bufPtr[LANE_W-1:0] == {LANE_W{1'b1}});

endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      doorbell,
  input  logic      memReqReady,
  input  logic      memRespValid,
  input  logic      txReady,
  input  dpStatus_t status,
  output strobes_t  stb,
  output logic      memReqValid,
  output logic      memReqWrite,
  output logic      txValid,
  output logic      descError
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_HEAD_REQ, ST_HEAD_WAIT, ST_CHECK, ST_PTR_REQ,
    ST_PTR_WAIT, ST_DATA_REQ, ST_DATA_WAIT, ST_SEND, ST_RETIRE
  } state_t;

  state_t state, nxt;
  logic   pendPoll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendPoll <= 1'b0;
    end else begin
      state    <= nxt;
      pendPoll <= (state == ST_IDLE) ? 1'b0 : (pendPoll | doorbell);
    end
  end

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.addrSel = SEL_HEAD;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    txValid     = 1'b0;
    descError   = 1'b0;
    unique case (state)
      ST_IDLE: if (doorbell || pendPoll) nxt = ST_HEAD_REQ;
      ST_HEAD_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_HEAD_WAIT;
      end
      ST_HEAD_WAIT: if (memRespValid) begin
        stb.loadHead = 1'b1;
        nxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (!status.owned) nxt = ST_IDLE;
        else if (!status.single) begin
          descError = 1'b1;
          nxt = ST_RETIRE;
        end else nxt = ST_PTR_REQ;
      end
      ST_PTR_REQ: begin
        stb.addrSel = SEL_PTR;
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_PTR_WAIT;
      end
      ST_PTR_WAIT: if (memRespValid) begin
        stb.loadPtr = 1'b1;
        nxt = status.lenZero ? ST_RETIRE : ST_DATA_REQ;
      end
      ST_DATA_REQ: begin
        stb.addrSel = SEL_DATA;
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_DATA_WAIT;
      end
      ST_DATA_WAIT: if (memRespValid) begin
        stb.loadWord = 1'b1;
        nxt = ST_SEND;
      end
      ST_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          stb.stepByte = 1'b1;
          if (status.lastByte) nxt = ST_RETIRE;
          else if (status.wordEnd) nxt = ST_DATA_REQ;
        end
      end
      ST_RETIRE: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          stb.advance = 1'b1;
          nxt = ST_HEAD_REQ;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
  parameter int AW    = 32,
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          baseWe,
  input  logic [AW-9:0] ringBaseHi,
  input  logic          doorbell,
  output logic          memReqValid,
  input  logic          memReqReady,
  output logic          memReqWrite,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic          memRespValid,
  input  logic [31:0]   memRespData,
  output logic          txValid,
  input  logic          txReady,
  output logic [7:0]    txData,
  output logic          descError
);

  txring_pkg::strobes_t  stb;
  txring_pkg::dpStatus_t status;

  txring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .doorbell(doorbell),
    .memReqReady(memReqReady), .memRespValid(memRespValid),
    .txReady(txReady), .status(status), .stb(stb),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .txValid(txValid), .descError(descError)
  );

  txring_dp #(.AW(AW), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .ringBaseHi(ringBaseHi),
    .stb(stb), .memRespData(memRespData), .memAddr(memAddr),
    .memWdata(memWdata), .txData(txData), .status(status)
  );

endmodule

// File: rtl/txring_chk.sv
module txring_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReqValid,
  input logic          memReqReady,
  input logic          memReqWrite,
  input logic [AW-1:0] memAddr,
  input logic [31:0]   memWdata,
  input logic          memRespValid,
  input logic          txValid,
  input logic          txReady,
  input logic [7:0]    txData,
  input logic          descError
);

  logic respOwed;

  always_ff @(posedge clk) begin
    if (!rstN) respOwed <= 1'b0;
    else if (memReqValid && memReqReady && !memReqWrite) respOwed <= 1'b1;
    else if (memRespValid) respOwed <= 1'b0;
  end

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr)
      && $stable(memReqWrite) && $stable(memWdata));

  assert_word_align_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memAddr[1:0] == 2'b00);

  assert_one_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    respOwed |-> !memReqValid);

  assert_handback_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> !memWdata[31]);

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    descError |=> !descError);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    descError |-> !txValid && !memReqValid);

  assert_stream_alone_R4: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !memReqValid);

endmodule

bind txring_engine txring_chk #(.AW(AW)) u_chk (.*);

// File: tb/txring_engine_tb.sv
`timescale 1ns/1ps
module txring_engine_tb;

  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWe = 1'b0;
  logic [23:0] ringBaseHi = '0;
  logic        doorbell = 1'b0;
  logic        memReqValid, memReqWrite, memReqReady;
  logic [31:0] memAddr, memWdata, memRespData;
  logic        memRespValid;
  logic        txValid, txReady, descError;
  logic [7:0]  txData;

  always #10 clk = ~clk;

  txring_engine #(.AW(AW), .IDX_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .ringBaseHi(ringBaseHi),
    .doorbell(doorbell), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .descError(descError)
  );

  // ---------------- memory model and monitors ----------------
  logic [31:0] mem [0:4095];
  logic        tbWrEn = 1'b0;
  logic [31:0] tbWrAddr = '0, tbWrData = '0;
  logic [31:0] rdAddr [0:4095];
  logic [31:0] wbAddr [0:4095];
  logic [31:0] wbData [0:4095];
  logic [7:0]  capB   [0:8191];
  int rdN = 0, wbN = 0, capN = 0, errN = 0, holdBad = 0, portBad = 0;
  logic prevStall = 1'b0, owed = 1'b0;
  logic [7:0] prevData = '0;

  function automatic logic [31:0] patt(input logic [11:0] i);
    logic [31:0] x;
    x = {20'b0, i};
    return (x * 32'h9E3779B1) ^ (x << 7) ^ 32'hA5C3_0F1E;
  endfunction

  function automatic logic [7:0] expByte(input logic [31:0] a);
    logic [31:0] w;
    w = patt(a[13:2]);
    return w[{a[1:0], 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] mkHead(input logic own, eor, fs, ls,
                                         input logic [15:0] len);
    return {own, eor, fs, ls, 12'h000, len};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4096; i++) mem[i] <= patt(12'(i));
      memRespValid <= 1'b0;
      memRespData  <= '0;
      memReqReady  <= 1'b0;
      txReady      <= 1'b0;
      prevStall    <= 1'b0;
      owed         <= 1'b0;
    end else begin
      memReqReady  <= ($urandom % 4) != 0;
      txReady      <= ($urandom % 3) != 0;
      memRespValid <= 1'b0;
      if (tbWrEn) mem[tbWrAddr[13:2]] <= tbWrData;
      if (memReqValid && (memAddr[1:0] != 2'b00 || owed)) portBad <= portBad + 1;
      if (memRespValid) owed <= 1'b0;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memAddr[13:2]] <= memWdata;
          if (wbN < 4096) begin wbAddr[wbN] <= memAddr; wbData[wbN] <= memWdata; end
          wbN <= wbN + 1;
        end else begin
          memRespValid <= 1'b1;
          memRespData  <= mem[memAddr[13:2]];
          owed         <= 1'b1;
          if (rdN < 4096) rdAddr[rdN] <= memAddr;
          rdN <= rdN + 1;
        end
      end
      if (txValid && txReady) begin
        if (capN < 8192) capB[capN] <= txData;
        capN <= capN + 1;
      end
      if (descError) errN <= errN + 1;
      if (prevStall && (!txValid || txData != prevData)) holdBad <= holdBad + 1;
      prevStall <= txValid && !txReady;
      prevData  <= txData;
    end
  end

  // ---------------- bench bookkeeping ----------------
  int total = 0, bad = 0;
  logic [7:0]  expB   [0:8191];
  logic [31:0] expWbA [0:63];
  logic [31:0] expWbD [0:63];
  int expN = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, d);
    @(negedge clk); tbWrEn = 1'b1; tbWrAddr = a; tbWrData = d;
    @(negedge clk); tbWrEn = 1'b0;
  endtask

  task automatic setDesc(input logic [31:0] base, input int idx,
                         input logic [31:0] w0, bufA);
    poke(base + 32'(idx * 16), w0);
    poke(base + 32'(idx * 16) + 32'd8, bufA);
  endtask

  task automatic setBase(input logic [31:0] b);
    @(negedge clk); baseWe = 1'b1; ringBaseHi = b[31:8];
    @(negedge clk); baseWe = 1'b0;
  endtask

  task automatic ring();
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectFrame(input logic [31:0] a, input int len);
    for (int k = 0; k < len; k++) begin
      expB[expN] = expByte(a + 32'(k));
      expN++;
    end
  endtask

  task automatic checkStream(input int capStart, input int expStart, input string tag);
    int mis;
    mis = 0;
    chk(capN - capStart == expN - expStart, {tag, " byte count"},
        32'(capN - capStart), 32'(expN - expStart));
    for (int k = 0; k < expN - expStart && k < capN - capStart; k++)
      if (capB[capStart + k] !== expB[expStart + k]) mis++;
    chk(mis == 0, {tag, " byte values"}, 32'(mis), 0);
  endtask

  task automatic checkWb(input int wbStart, input int n, input string tag);
    chk(wbN - wbStart == n, {tag, " handback count"}, 32'(wbN - wbStart), 32'(n));
    for (int k = 0; k < n && wbStart + k < wbN; k++) begin
      chk(wbAddr[wbStart + k] == expWbA[k], {tag, " handback address"},
          wbAddr[wbStart + k], expWbA[k]);
      chk(wbData[wbStart + k] == expWbD[k], {tag, " handback word"},
          wbData[wbStart + k], expWbD[k]);
    end
  endtask

  function automatic int countReads(input int from, input logic [31:0] a);
    int c;
    c = 0;
    for (int k = from; k < rdN; k++) if (rdAddr[k] == a) c++;
    return c;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int cs, es, ws, rs, q;
    logic [31:0] w0, b;
    void'($urandom(32'd4021));
    idle(5);
    rstN = 1'b1;
    @(negedge clk);
    chk(!txValid && !memReqValid && !descError, "R1 outputs after reset",
        {29'b0, txValid, memReqValid, descError}, 0);
    idle(50);
    chk(rdN == 0 && wbN == 0, "R1 no request before doorbell", 32'(rdN + wbN), 0);

    // A: short, zero-length and unaligned frames, ring at 0x100
    w0 = mkHead(1, 0, 1, 1, 16'd5);                 setDesc(32'h100, 0, w0, 32'h1003);
    expWbA[0] = 32'h100; expWbD[0] = {1'b0, w0[30:0]};
    w0 = mkHead(1, 0, 1, 1, 16'd0);                 setDesc(32'h100, 1, w0, 32'h1100);
    expWbA[1] = 32'h110; expWbD[1] = {1'b0, w0[30:0]};
    w0 = mkHead(1, 0, 1, 1, 16'd13) | 32'h0AB0_0000; setDesc(32'h100, 2, w0, 32'h1202);
    expWbA[2] = 32'h120; expWbD[2] = {1'b0, w0[30:0]};
    setDesc(32'h100, 3, 32'h0, 32'h0);
    cs = capN; es = expN; ws = wbN; rs = rdN;
    expectFrame(32'h1003, 5); expectFrame(32'h1202, 13);
    setBase(32'h100);
    ring();
    idle(1500);
    chk(rdAddr[rs] == 32'h100, "R2 first fetch address", rdAddr[rs], 32'h100);
    chk(rdAddr[rs + 1] == 32'h108, "R4 pointer word address", rdAddr[rs + 1], 32'h108);
    checkStream(cs, es, "R4 unpadded short frames");
    checkWb(ws, 3, "R6 R7 R5 sequential handback");

    // R3: rewriting the base restarts at slot 0
    w0 = mkHead(1, 0, 1, 1, 16'd2); setDesc(32'h100, 0, w0, 32'h1301);
    cs = capN; es = expN; rs = rdN;
    expectFrame(32'h1301, 2);
    setBase(32'h100);
    ring();
    idle(800);
    chk(rdAddr[rs] == 32'h100, "R3 index cleared by base write", rdAddr[rs], 32'h100);
    checkStream(cs, es, "R3 frame after base write");

    // B: bad frame flags are skipped with an error pulse
    w0 = mkHead(1, 0, 1, 0, 16'd4); setDesc(32'h200, 0, w0, 32'h1400);
    expWbA[0] = 32'h200; expWbD[0] = {1'b0, w0[30:0]};
    w0 = mkHead(1, 0, 1, 1, 16'd3); setDesc(32'h200, 1, w0, 32'h1500);
    expWbA[1] = 32'h210; expWbD[1] = {1'b0, w0[30:0]};
    setDesc(32'h200, 2, 32'h0, 32'h0);
    cs = capN; es = expN; ws = wbN; q = errN;
    expectFrame(32'h1500, 3);
    setBase(32'h200);
    ring();
    idle(800);
    chk(errN - q == 1, "R10 single error pulse", 32'(errN - q), 1);
    checkStream(cs, es, "R10 skipped descriptor sends nothing");
    checkWb(ws, 2, "R10 skipped descriptor handed back");

    // C: end-of-ring wrap; slot 2 is owned but must never be reached
    w0 = mkHead(1, 0, 1, 1, 16'd4); setDesc(32'h300, 0, w0, 32'h2000);
    w0 = mkHead(1, 1, 1, 1, 16'd6); setDesc(32'h300, 1, w0, 32'h2101);
    w0 = mkHead(1, 0, 1, 1, 16'd9); setDesc(32'h300, 2, w0, 32'h2400);
    cs = capN; es = expN; ws = wbN;
    expectFrame(32'h2000, 4); expectFrame(32'h2101, 6);
    setBase(32'h300);
    ring();
    idle(1000);
    checkStream(cs, es, "R7 frames before wrap");
    chk(rdAddr[rdN - 1] == 32'h300, "R7 fetch after end of ring", rdAddr[rdN - 1], 32'h300);
    chk(wbN - ws == 2, "R7 trap slot untouched", 32'(wbN - ws), 2);
    w0 = mkHead(1, 0, 1, 1, 16'd3); setDesc(32'h300, 0, w0, 32'h2203);
    cs = capN; es = expN; ws = wbN;
    expectFrame(32'h2203, 3);
    ring();
    idle(800);
    checkStream(cs, es, "R7 frame at wrapped slot");
    chk(wbN - ws == 1 && wbAddr[ws] == 32'h300, "R7 wrapped handback address",
        wbAddr[ws], 32'h300);
    chk(rdAddr[rdN - 1] == 32'h310, "R7 index moves past wrapped slot",
        rdAddr[rdN - 1], 32'h310);

    // D: doorbell during a long frame is held for one more poll
    w0 = mkHead(1, 0, 1, 1, 16'd40); setDesc(32'h400, 0, w0, 32'h2A01);
    setDesc(32'h400, 1, 32'h0, 32'h0);
    cs = capN; es = expN; rs = rdN;
    expectFrame(32'h2A01, 40);
    setBase(32'h400);
    ring();
    idle(20);
    ring();
    idle(1000);
    checkStream(cs, es, "R4 long frame");
    chk(countReads(rs, 32'h410) == 2, "R9 held doorbell repolls",
        32'(countReads(rs, 32'h410)), 2);
    q = rdN + wbN;
    idle(200);
    chk(rdN + wbN == q, "R8 quiet after unowned descriptor", 32'(rdN + wbN), 32'(q));

    // E: slot 0 of a fresh base, unowned
    setDesc(32'h500, 0, mkHead(0, 0, 1, 1, 16'd8), 32'h3000);
    rs = rdN; ws = wbN; cs = capN;
    setBase(32'h5A7);
    ring();
    idle(200);
    chk(rdN - rs == 1 && rdAddr[rs] == 32'h500, "R2 aligned base fetch",
        rdAddr[rs], 32'h500);
    chk(wbN == ws && capN == cs, "R8 unowned gives no write or bytes",
        32'(wbN - ws + capN - cs), 0);

    // Random rounds
    for (int r = 0; r < 10; r++) begin
      int n, len;
      bit eorLast;
      logic [31:0] base;
      base = (r % 2 == 0) ? 32'h600 : 32'h700;
      n = 1 + int'($urandom % 4);
      eorLast = 1'($urandom % 2);
      cs = capN; es = expN; ws = wbN;
      for (int i = 0; i < n; i++) begin
        len = int'($urandom % 25);
        b = 32'h800 + ($urandom % 32'h3000);
        w0 = mkHead(1, eorLast && (i == n - 1), 1, 1, 16'(len))
             | ($urandom & 32'h0FFF_0000);
        setDesc(base, i, w0, b);
        expWbA[i] = base + 32'(i * 16);
        expWbD[i] = {1'b0, w0[30:0]};
        expectFrame(b, len);
      end
      setDesc(base, n, 32'h0, 32'h0);
      setBase(base);
      ring();
      idle(1500);
      checkStream(cs, es, "R4 random frames");
      checkWb(ws, n, "R6 random handback");
    end

    chk(holdBad == 0, "R11 byte held while stalled", 32'(holdBad), 0);
    chk(portBad == 0, "R12 one read, aligned addresses", 32'(portBad), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule